// File: doc/BRIEF.md
# Interpolating Bit-Clock Recovery Loop

This block recovers a receive bit clock from demodulated NRZ data so that a serial HDLC controller can clock its receiver. It runs from a single clock at eight times the bit rate. For example, a 9.8304 MHz clock serves 1.2288 Mbit/s. Bit phase is held in a fine accumulator rather than in a fast counter. The loop therefore resolves the bit phase to 1/256 of a bit, the same as a divide-by-256 loop, while ticking only eight times per bit.

Each data transition that the synchronizer sees is taken as a phase measurement. An eighth of that error is removed from the next accumulator step, which gives a first-order loop. Data is retimed at the middle of the bit.

While the transmitter is keyed, correction stops and the same output serves as a steady, uncorrected transmit clock. This suits simplex links that use one clock for both directions. A static input inverts the clock polarity. A carrier-detect flag reports whether enough transitions land near their expected phase over a fixed window.

Top module: `bitsync_dpll`

## Requirements
- R1: While rst_ni is low, bit_clk_o equals clk_inv_i, rx_data_o is 0 and carrier_o is 0.
- R2: With no data transitions, the 8-bit phase accumulator steps by 32 per clock. bit_clk_o (with clk_inv_i low) is the accumulator MSB: k clocks after reset release it equals 1 exactly when (32*k mod 256) >= 128, so the period is 8 clocks with 4 clocks high.
- R3: With clk_inv_i high, bit_clk_o is the inverse of the R2 waveform.
- R4: rx_data_i passes through two registers. A transition between them is taken as an edge, and the phase error is the accumulator read as a signed 8-bit value. On an edge, the step becomes 32 minus (error arithmetically shifted right by 3). For example, an edge seen at accumulator value 32 gives a step of 28, which delays the next bit-clock rise by one clock.
- R5: With input bits lasting exactly 8 clocks and changing at a clock's falling edge, the loop locks. After lock, bit_clk_o is 1 before each bit boundary and 0 on the first rising clock edge after the boundary.
- R6: rx_data_o takes the synchronized data on the clock where the accumulator crosses 128, which is the rise of the uninverted bit clock. In lock, it equals the bit currently being received.
- R7: While tx_en_i is high, every step is exactly 32 whatever the data, so the bit clock keeps its phase and its 8-clock period.
- R8: carrier_o changes only at the end of each 512-clock window (64 bits). It is then set to 1 when the number of edges in that window with an error between -32 and +32 inclusive is strictly greater than carrier_thr_i. A window with no edges gives 0.
- R9: The threshold compare is strict. Locked alternating data gives exactly 64 good edges per window, so a threshold of 63 sets carrier_o and a threshold of 64 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, 8x bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Demodulated NRZ data |
| tx_en_i | input | 1 | Transmit keyed; freezes the loop |
| clk_inv_i | input | 1 | Invert bit_clk_o |
| carrier_thr_i | input | 7 | Carrier-detect threshold, good-edge count per window |
| bit_clk_o | output | 1 | Recovered or free-running bit clock |
| rx_data_o | output | 1 | Data retimed at mid-bit |
| carrier_o | output | 1 | Carrier-detect flag |

## Verification
A change on rx_data_i is registered on the next rising clock edge and appears as an edge one clock later. The corrected step therefore shows in the accumulator two clock edges after the change, and its effect on bit_clk_o shows on the next MSB crossing. The bench drives data on falling edges and samples on the falling edge that follows the counted number of rising edges. Once locked, it expects the bit clock to fall after one rising edge and to rise together with new retimed data after five. For carrier_o, the bench waits well over two whole windows before sampling, so the flag always reflects a window that lay entirely inside the stimulus phase.

// File: rtl/bitsync_pkg.sv
package bitsync_pkg;
  localparam int unsigned PH_W_DEF     = 8;   // accumulator width
  localparam int unsigned OSR_LOG_DEF  = 3;   // log2 of oversampling
  localparam int unsigned GAIN_DEF     = 3;   // error shift
  localparam int unsigned WIN_BITS_DEF = 64;  // carrier window in bits
  localparam int unsigned TOL_DEF      = 32;  // good-edge tolerance
endpackage

// File: rtl/bitsync_sampler.sv
module bitsync_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic level_o,
  output logic edge_o
);
  logic level_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      level_q <= rx_i;
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign edge_o  = level_q ^ prev_q;
endmodule

// File: rtl/bitsync_nco.sv
module bitsync_nco #(
  parameter int unsigned PH_W       = 8,
  parameter int unsigned OSR_LOG    = 3,
  parameter int unsigned GAIN_SHIFT = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   edge_i,
  input  logic                   freeze_i,
  output logic [PH_W-1:0]        phase_o,
  output logic signed [PH_W-1:0] err_o,
  output logic                   mid_o
);
  localparam int unsigned STEP = 2 ** (PH_W - OSR_LOG);

  logic [PH_W-1:0]        acc_q, acc_d;
  logic signed [PH_W-1:0] corr;
  logic signed [PH_W+1:0] inc;

  assign err_o = $signed(acc_q);    // expected edge phase is zero
  assign corr  = err_o >>> GAIN_SHIFT;

  always_comb begin
    inc = (PH_W+2)'(STEP);
    if (edge_i && !freeze_i) inc = inc - {{2{corr[PH_W-1]}}, corr};
    acc_d = acc_q + inc[PH_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign phase_o = acc_q;
  assign mid_o   = !acc_q[PH_W-1] && acc_d[PH_W-1];
endmodule

// File: rtl/bitsync_dcd.sv
module bitsync_dcd #(
  parameter int unsigned PH_W      = 8,
  parameter int unsigned WIN_TICKS = 512,
  parameter int unsigned TOL       = 32,
  parameter int unsigned THR_W     = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   edge_i,
  input  logic signed [PH_W-1:0] err_i,
  input  logic [THR_W-1:0]       thresh_i,
  output logic                   dcd_o,
  output logic                   win_end_o
);
  localparam int unsigned WIN_W = $clog2(WIN_TICKS);
  localparam int unsigned CNT_W = $clog2(WIN_TICKS + 1);
  localparam logic signed [PH_W-1:0] TOL_P = PH_W'(TOL);
  localparam logic signed [PH_W-1:0] TOL_N = -TOL_P;

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q, cnt_sum;
  logic             good, dcd_q;

  assign good      = edge_i && (err_i >= TOL_N) && (err_i <= TOL_P);
  assign cnt_sum   = cnt_q + CNT_W'(good);
  assign win_end_o = (win_q == WIN_W'(WIN_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
      dcd_q <= 1'b0;
    end else begin
      win_q <= win_end_o ? '0 : win_q + 1'b1;
      if (win_end_o) begin
        cnt_q <= '0;
        dcd_q <= cnt_sum > CNT_W'(thresh_i);
      end else begin
        cnt_q <= cnt_sum;
      end
    end
  end

  assign dcd_o = dcd_q;
endmodule

// File: rtl/bitsync_dpll.sv
module bitsync_dpll
  import bitsync_pkg::*;
#(
  parameter int unsigned PH_W       = PH_W_DEF,
  parameter int unsigned OSR_LOG    = OSR_LOG_DEF,
  parameter int unsigned GAIN_SHIFT = GAIN_DEF,
  parameter int unsigned WIN_BITS   = WIN_BITS_DEF,
  parameter int unsigned TOL        = TOL_DEF,
  parameter int unsigned THR_W      = $clog2(WIN_BITS) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_data_i,
  input  logic             tx_en_i,
  input  logic             clk_inv_i,
  input  logic [THR_W-1:0] carrier_thr_i,
  output logic             bit_clk_o,
  output logic             rx_data_o,
  output logic             carrier_o
);
  localparam int unsigned WIN_TICKS = WIN_BITS << OSR_LOG;

  logic                   rx_level, rx_edge, mid, win_end, rx_q;
  logic [PH_W-1:0]        phase;
  logic signed [PH_W-1:0] err;

  bitsync_sampler u_samp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_data_i),
    .level_o(rx_level),
    .edge_o (rx_edge)
  );

  bitsync_nco #(.PH_W(PH_W), .OSR_LOG(OSR_LOG), .GAIN_SHIFT(GAIN_SHIFT)) u_nco (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .edge_i  (rx_edge),
    .freeze_i(tx_en_i),
    .phase_o (phase),
    .err_o   (err),
    .mid_o   (mid)
  );

  bitsync_dcd #(.PH_W(PH_W), .WIN_TICKS(WIN_TICKS), .TOL(TOL), .THR_W(THR_W)) u_dcd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (rx_edge),
    .err_i    (err),
    .thresh_i (carrier_thr_i),
    .dcd_o    (carrier_o),
    .win_end_o(win_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rx_q <= 1'b0;
    else if (mid) rx_q <= rx_level;
  end

  assign rx_data_o = rx_q;
  assign bit_clk_o = phase[PH_W-1] ^ clk_inv_i;
endmodule

// File: rtl/bitsync_dpll_chk.sv
module bitsync_dpll_chk #(
  parameter int unsigned PH_W       = 8,
  parameter int unsigned OSR_LOG    = 3,
  parameter int unsigned GAIN_SHIFT = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tx_en_i,
  input logic            edge_i,
  input logic            level_i,
  input logic            win_end_i,
  input logic [PH_W-1:0] acc_i,
  input logic            rx_data_o,
  input logic            carrier_o
);
  localparam int unsigned STEP = 2 ** (PH_W - OSR_LOG);
  localparam int unsigned SPAN = 2 ** (PH_W - 1 - GAIN_SHIFT);
  localparam logic [PH_W-1:0] STEP_P = PH_W'(STEP);
  localparam logic [PH_W-1:0] STEP_LO = PH_W'(STEP - SPAN);
  localparam logic [PH_W-1:0] STEP_HI = PH_W'(STEP + SPAN);

  logic [PH_W-1:0] prev_q, step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= acc_i;
  end
  assign step = acc_i - prev_q;

  assert_idle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> step == STEP_P);

  assert_corr_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i |=> (step >= STEP_LO) && (step <= STEP_HI));

  assert_frozen_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_i |=> step == STEP_P);

  assert_retime_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(acc_i[PH_W-1]) |-> rx_data_o == $past(level_i));

  assert_carrier_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(carrier_o));
endmodule

bind bitsync_dpll bitsync_dpll_chk #(
  .PH_W(PH_W), .OSR_LOG(OSR_LOG), .GAIN_SHIFT(GAIN_SHIFT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tx_en_i  (tx_en_i),
  .edge_i   (rx_edge),
  .level_i  (rx_level),
  .win_end_i(win_end),
  .acc_i    (phase),
  .rx_data_o(rx_data_o),
  .carrier_o(carrier_o)
);

// File: tb/bitsync_dpll_test.sv
module bitsync_dpll_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       rx = 1'b0, tx_en = 1'b0, inv = 1'b0;
  logic [6:0] thr = '0;
  logic       bclk, rxd, car;
  int total = 0, bad = 0;

  bitsync_dpll uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx), .tx_en_i(tx_en),
    .clk_inv_i(inv), .carrier_thr_i(thr),
    .bit_clk_o(bclk), .rx_data_o(rxd), .carrier_o(car)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx = 1'b0; tx_en = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  // one bit of 8 clocks, driven at a falling edge; lock checks optional
  task automatic send_bit(input logic b, input bit check);
    if (check) chk(bclk == 1'b1, "R5 clk high before boundary", int'(bclk), 1);
    rx = b;
    tick(1);
    if (check) chk(bclk == 1'b0, "R5 clk falls after boundary", int'(bclk), 0);
    tick(4);
    if (check) begin
      chk(bclk == 1'b1, "R6 clk rise at mid-bit", int'(bclk), 1);
      chk(rxd == b, "R6 retimed data", int'(rxd), int'(b));
    end
    tick(3);
  endtask

  initial begin
    logic [15:0] lfsr;
    logic        lvl;
    // R1 reset state, both polarities
    tick(1);
    chk(bclk == 1'b0 && rxd == 1'b0 && car == 1'b0, "R1 reset outputs",
        int'({bclk, rxd, car}), 0);
    inv = 1'b1; tick(1);
    chk(bclk == 1'b1, "R1 reset clk follows inv", int'(bclk), 1);
    inv = 1'b0;

    // R2 free-running waveform
    do_reset();
    for (int k = 1; k <= 40; k++) begin
      tick(1);
      chk(bclk == (((32 * k) % 256) >= 128), "R2 free-run clk", int'(bclk),
          int'(((32 * k) % 256) >= 128));
    end

    // R3 inverted polarity
    inv = 1'b1;
    do_reset();
    for (int k = 1; k <= 16; k++) begin
      tick(1);
      chk(bclk == (((32 * k) % 256) < 128), "R3 inverted clk", int'(bclk),
          int'(((32 * k) % 256) < 128));
    end
    inv = 1'b0;

    // R4 edge at accumulator 32: step 28, rise delayed to 5 clocks
    do_reset();
    rx = 1'b1;
    tick(4);
    chk(bclk == 1'b0, "R4 err 32 rise delayed", int'(bclk), 0);
    tick(1);
    chk(bclk == 1'b1, "R4 err 32 rise", int'(bclk), 1);
    chk(rxd == 1'b1, "R6 captured at rise", int'(rxd), 1);

    // R4 edge at accumulator 64: step 24
    do_reset();
    tick(1);
    rx = 1'b1;
    tick(3);
    chk(bclk == 1'b0, "R4 err 64 rise delayed", int'(bclk), 0);
    tick(1);
    chk(bclk == 1'b1, "R4 err 64 rise", int'(bclk), 1);

    // R5/R6 acquisition then random data in lock
    do_reset();
    thr = 7'd63;
    tick(3);
    lvl = 1'b0;
    for (int n = 0; n < 64; n++) begin lvl = ~lvl; send_bit(lvl, 1'b0); end
    lfsr = 16'hACE1;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_bit(lfsr[0], 1'b1);
    end

    // R8/R9 carrier detect with alternating locked data
    lvl = rx;
    for (int n = 0; n < 200; n++) begin lvl = ~lvl; send_bit(lvl, 1'b1); end
    chk(car == 1'b1, "R9 64 good edges over threshold 63", int'(car), 1);
    thr = 7'd64;
    for (int n = 0; n < 200; n++) begin lvl = ~lvl; send_bit(lvl, 1'b1); end
    chk(car == 1'b0, "R9 64 good edges not over threshold 64", int'(car), 0);
    thr = 7'd63;
    for (int n = 0; n < 200; n++) begin lvl = ~lvl; send_bit(lvl, 1'b1); end
    chk(car == 1'b1, "R8 carrier reasserts", int'(car), 1);
    thr = 7'd0;
    for (int n = 0; n < 200; n++) send_bit(lvl, 1'b1);
    chk(car == 1'b0, "R8 no edges clears carrier", int'(car), 0);

    // R7 freeze with misaligned transitions
    tx_en = 1'b1;
    for (int n = 0; n < 22; n++) begin
      for (int j = 0; j < 8; j++) begin
        chk(bclk == (j == 0 || j >= 5), "R7 frozen clk", int'(bclk),
            int'(j == 0 || j >= 5));
        if (j == 3 && n < 20) begin lvl = ~lvl; rx = lvl; end
        tick(1);
      end
    end
    tx_en = 1'b0;
    for (int n = 0; n < 4; n++) send_bit(lvl, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule